// File: doc/BRIEF.md
# Cascaded Frame-Sync Slot Controller

This block times one codec serial port that shares its bit clock and its data output line with up to seven other devices in a daisy chain. Every device owns two 32-bit-clock slots per frame: a primary slot for conversion data and a secondary slot for control information. The order of slots in a frame is the master's primary slot, then the slave primaries in chain order, then the master's secondary slot, then the slave secondaries in chain order. A device shifts out a word only inside its own slots. It releases the output line, with its output enable low, at every other time.

In master mode the block builds the frame locally. It sends a frame-sync pulse to the host and starts its own primary slot with that pulse. Thirty-two clocks later it passes a delayed frame sync to the first slave. If a secondary frame is requested, the master issues a second host pulse once every primary slot has gone by, which is (address + 1) × 32 clocks after the first pulse. The master's cascade address equals the number of slaves in the chain. In slave mode the block takes its timing from the delayed frame sync of the device before it and relays that pulse down the chain 32 clocks later.

The data and control words are plain level inputs. The block samples them in the frame-sync cycle, so it applies no back-pressure and has no valid/ready handshake.

Top module: `cascade_fs_slot_ctrl`

## Requirements
- R1: After a synchronous reset, `fs_out`, `fsd_out` and `dout_en` are low and `dout` is 0 until the first accepted frame sync.
- R2: With `master_sel` = 1, `fs_out` is a one-cycle pulse every FRAME_LEN (512) cycles. The first pulse appears in the second cycle after reset is released, and each pulse starts this device's slot.
- R3: With `master_sel` = 0, `fs_out` stays low, and a slot starts in the cycle where `fs_in` is high and is accepted.
- R4: In cycles 1 to 16 after the frame-sync cycle that starts a slot, `dout_en` is high and `dout` carries the sampled word from bit 15 down to bit 0, one bit per cycle.
- R5: `dout_en` is low and `dout` is 0 in cycles 17 to 32 of a slot and whenever no slot of this device is running.
- R6: `fsd_out` is high for exactly one cycle, 32 cycles after the frame sync that started the slot.
- R7: In slave mode, an `fs_in` pulse that arrives 1 to 31 cycles after an accepted pulse is ignored. A pulse that arrives exactly 32 cycles after it starts a new slot.
- R8: A primary slot sends `data_word` and a secondary slot sends `ctrl_word`. In slave mode, accepted pulses alternate between primary and secondary, and the first accepted pulse after reset is primary.
- R9: In master mode, when `sec_req` is high in the primary `fs_out` cycle, a second `fs_out` pulse follows (`casc_addr` + 1) × 32 cycles later and starts the secondary slot. When `sec_req` is low in that cycle, no second pulse follows in that frame.
- R10: The word is captured in the frame-sync cycle. Changes to `data_word` or `ctrl_word` after that cycle do not change the bits sent in the running slot.
- R11: In master mode, `fs_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 1 = master, 0 = slave |
| fs_in | input | 1 | Frame sync from the previous device (slave mode) |
| sec_req | input | 1 | Request a secondary frame (master mode) |
| casc_addr | input | 3 | Position in the chain; on the master, the number of slaves |
| data_word | input | 16 | Word sent in the primary slot |
| ctrl_word | input | 16 | Word sent in the secondary slot |
| fs_out | output | 1 | Frame-sync pulse to the host (master mode) |
| fsd_out | output | 1 | Delayed frame sync to the next device |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | High while `dout` must be driven onto the shared line |

## Verification
The hardest situations to reach are those where two slot events land on the same cycle. One is a master with address 0, whose secondary pulse falls in the same cycle as its own delayed frame sync. The other is a slave that receives a new pulse exactly 32 cycles after the previous one. The stimulus builds both cases on purpose. It also sends a stray pulse in the middle of a slot and changes the words while a slot is running. A behavioural model that counts cycle ages compares all four outputs on every cycle, so an accepted pulse or a dropped pulse shows up at once.

// File: rtl/cascade_fs_pkg.sv
package cascade_fs_pkg;
  typedef enum logic {SLOT_PRI = 1'b0, SLOT_SEC = 1'b1} slot_kind_t;
endpackage

// File: rtl/cfs_master_timer.sv
module cfs_master_timer
  import cascade_fs_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int SLOT_LEN  = 32,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_req,
  input  logic [ADDR_W-1:0] casc_addr,
  output logic              fs_pulse,
  output slot_kind_t        kind
);
  localparam int FW = $clog2(FRAME_LEN);

  logic [FW-1:0] fcnt;
  logic [FW-1:0] sec_off;
  logic          sec_armed;
  logic          at_start;

  assign at_start = (fcnt == '0);
  assign sec_off  = FW'((int'(casc_addr) + 1) * SLOT_LEN);
  assign fs_pulse = at_start || (sec_armed && (fcnt == sec_off));
  assign kind     = at_start ? SLOT_PRI : SLOT_SEC;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt      <= FW'(FRAME_LEN - 1);
      sec_armed <= 1'b0;
    end else begin
      fcnt <= (fcnt == FW'(FRAME_LEN - 1)) ? '0 : fcnt + 1'b1;
      if (at_start) sec_armed <= sec_req;
    end
  end
endmodule

// File: rtl/cfs_word_select.sv
module cfs_word_select
  import cascade_fs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              start,
  input  slot_kind_t        master_kind,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] word
);
  slot_kind_t next_kind;
  slot_kind_t kind;

  assign kind = is_master ? master_kind : next_kind;
  assign word = (kind == SLOT_SEC) ? ctrl_word : data_word;

  always_ff @(posedge clk) begin
    if (rst) next_kind <= SLOT_PRI;
    else if (start && !is_master)
      next_kind <= (next_kind == SLOT_PRI) ? SLOT_SEC : SLOT_PRI;
  end
endmodule

// File: rtl/cfs_slot_engine.sv
module cfs_slot_engine #(
  parameter int SLOT_LEN = 32,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              can_accept,
  output logic              fsd,
  output logic              dout,
  output logic              dout_en
);
  localparam int CW = $clog2(SLOT_LEN + 1);

  logic [CW-1:0]     scnt;
  logic              busy;
  logic [WORD_W-1:0] sreg;

  assign can_accept = !busy || (scnt == CW'(SLOT_LEN));
  assign fsd        = busy && (scnt == CW'(SLOT_LEN));
  assign dout_en    = busy && (scnt <= CW'(WORD_W));
  assign dout       = dout_en && sreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      scnt <= '0;
      sreg <= '0;
    end else if (start) begin
      busy <= 1'b1;
      scnt <= CW'(1);
      sreg <= word;
    end else if (busy) begin
      if (scnt == CW'(SLOT_LEN)) begin
        busy <= 1'b0;
        scnt <= '0;
      end else begin
        scnt <= scnt + 1'b1;
      end
      if (scnt < CW'(WORD_W)) sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/cascade_fs_slot_ctrl.sv
module cascade_fs_slot_ctrl
  import cascade_fs_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int WORD_W    = 16,
  parameter int SLOT_LEN  = 32,
  parameter int FRAME_LEN = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_sel,
  input  logic              fs_in,
  input  logic              sec_req,
  input  logic [ADDR_W-1:0] casc_addr,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic              fs_out,
  output logic              fsd_out,
  output logic              dout,
  output logic              dout_en
);
  logic              m_pulse;
  slot_kind_t        m_kind;
  logic              can_accept;
  logic              start;
  logic [WORD_W-1:0] word;

  cfs_master_timer #(.FRAME_LEN(FRAME_LEN), .SLOT_LEN(SLOT_LEN), .ADDR_W(ADDR_W)) u_timer (
    .clk(clk), .rst(rst), .sec_req(sec_req), .casc_addr(casc_addr),
    .fs_pulse(m_pulse), .kind(m_kind)
  );

  assign fs_out = master_sel && m_pulse;
  assign start  = master_sel ? m_pulse : (fs_in && can_accept);

  cfs_word_select #(.WORD_W(WORD_W)) u_sel (
    .clk(clk), .rst(rst), .is_master(master_sel), .start(start),
    .master_kind(m_kind), .data_word(data_word), .ctrl_word(ctrl_word), .word(word)
  );

  cfs_slot_engine #(.SLOT_LEN(SLOT_LEN), .WORD_W(WORD_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .word(word),
    .can_accept(can_accept), .fsd(fsd_out), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
  input logic clk,
  input logic rst,
  input logic master_sel,
  input logic fs_out,
  input logic fsd_out,
  input logic dout,
  input logic dout_en
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!fs_out && !fsd_out && !dout_en && !dout)); // R1
  AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fs_out |=> !fs_out); // R2
  AST_SLAVE_NO_FS: assert property (@(posedge clk) disable iff (rst)
    !master_sel |-> !fs_out); // R3
  AST_FS_STARTS_WORD: assert property (@(posedge clk) disable iff (rst)
    fs_out |=> dout_en); // R4
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> !dout); // R5
  AST_FSD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fsd_out |=> !fsd_out); // R6
  AST_FSD_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
    fsd_out |-> (!dout_en && $past(dout_en, 16))); // R6
endmodule

bind cascade_fs_slot_ctrl cfs_checker u_chk (.*);

// File: tb/cascade_fs_slot_ctrl_test.sv
module cascade_fs_slot_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        b_rst = 1'b1, b_master = 1'b0, b_fs = 1'b0, b_sec = 1'b0;
  logic [2:0]  b_addr = 3'd0;
  logic [15:0] b_data = 16'h0, b_ctrl = 16'h0;
  logic        fs_out, fsd_out, dout, dout_en;

  cascade_fs_slot_ctrl uut (
    .clk(clk), .rst(b_rst), .master_sel(b_master), .fs_in(b_fs), .sec_req(b_sec),
    .casc_addr(b_addr), .data_word(b_data), .ctrl_word(b_ctrl),
    .fs_out(fs_out), .fsd_out(fsd_out), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0, errors = 0, cycles = 0;
  // behavioural model state
  int mpos = 511, age = -1;
  bit sec_arm = 0, slave_sec = 0;
  logic [15:0] mword = 16'h0;

  function automatic bit exp_fs();
    return b_master && (mpos == 0 || (sec_arm && mpos == (int'(b_addr) + 1) * 32));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  task automatic tick();
    bit st, sec;
    @(posedge clk);
    cycles++;
    if (b_rst) begin
      mpos = 511; sec_arm = 0; age = -1; slave_sec = 0;
    end else begin
      // R11: in master mode only the local timer starts slots
      st  = b_master ? exp_fs() : (b_fs && !(age >= 1 && age <= 31)); // R7
      sec = b_master ? (mpos != 0) : slave_sec;                       // R8
      if (st) begin
        age = 1;
        mword = sec ? b_ctrl : b_data;                                 // R10
        if (!b_master) slave_sec = !slave_sec;
      end else if (age >= 1 && age < 32) age++;
      else age = -1;
      if (mpos == 0) sec_arm = b_sec;                                  // R9
      mpos = (mpos + 1) % 512;
    end
    @(negedge clk);
    begin
      bit en;
      en = (age >= 1 && age <= 16);
      check("R2 R3 R9 fs_out", fs_out, exp_fs());
      check("R6 fsd_out", fsd_out, age == 32);
      check("R4 R5 dout_en", dout_en, en);
      check("R4 R5 R8 R10 dout", dout, en ? mword[16 - age] : 1'b0);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_fs();
    b_fs = 1'b1; tick(); b_fs = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    run(3);
    b_rst = 1'b0;
    run(5);                              // R1: quiet until frame sync
    // slave: primary then secondary, stray pulse mid-slot, word change mid-slot
    b_data = 16'hA5C3; b_ctrl = 16'h3C96;
    pulse_fs();                          // R3 R8 primary
    b_data = 16'hFFFF;                   // R10
    run(9);
    pulse_fs();                          // R7 ignored
    run(30);
    b_ctrl = 16'h8001;
    pulse_fs();                          // R8 secondary
    run(31);
    b_data = 16'h1234;
    pulse_fs();                          // R7 exactly 32 later: accepted
    run(31);
    b_ctrl = 16'h0F0F;
    pulse_fs();
    run(45);
    // master with three slaves, secondary requested
    b_rst = 1'b1; run(2);
    b_master = 1'b1; b_addr = 3'd3; b_sec = 1'b1; b_rst = 1'b0;
    b_data = 16'hC001; b_ctrl = 16'h7E11;
    for (int i = 0; i < 40; i++) begin  // R11: fs_in toggles in master mode
      b_fs = i[0]; tick();
    end
    b_fs = 1'b0;
    run(560);
    b_sec = 1'b0;                        // R9 no secondary next frame
    run(520);
    // master address 0: secondary coincides with own delayed sync
    b_addr = 3'd0; b_sec = 1'b1; b_data = 16'h55AA; b_ctrl = 16'hF00D;
    run(1100);
    b_rst = 1'b1; run(1);
    b_rst = 1'b0; run(3);                // R1 after second reset
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule